// File: doc/BRIEF.md
# Serial Audio Link Controller

The block moves stereo 16-bit audio between a register bus and a three-wire serial link made of a bit clock, a frame sync and a data line in each direction. Software, or a DMA engine driven by the two service request outputs, writes packed sample pairs into a 16-entry transmit queue and reads captured pairs from a 16-entry receive queue. A framing state machine serialises one left and one right sample per frame in either I2S or MSB-justified framing. The bit clock is generated from the system clock through a programmable divider, or taken from outside.

The framing engine has three states. FR_IDLE is entered from reset and whenever the link stops. The transition FR_IDLE to FR_LEFT happens on a bit clock falling edge when the link is enabled and at least one direction is on, and it loads the next transmit word. FR_LEFT to FR_RIGHT happens after the sixteenth left bit. FR_RIGHT to FR_LEFT happens after the sixteenth right bit while the link is still wanted, and it loads the next word. FR_RIGHT to FR_IDLE happens after that same bit when the link has been switched off, so a frame that has started always completes.

Registers sit at word indices on a 3-bit address, and reads return data one cycle after the read strobe. The interrupt line is the OR of the enabled status flags.

Top module: `serial_audio_link`

## Requirements
- R1: Register indices are control 0, mode 1, status 2, mask 3, clear 4, divider 5 and data 6. After reset the status reads 0x99, the mode reads 0x18 and the control, divider and mask read 0.
- R2: A write to the data index pushes a word {left[31:16], right[15:0]} into the transmit queue, and a read pops the receive queue. Each queue holds 16 words, a push into a full queue is dropped, status bit 0 means transmit not full and status bit 1 means receive not empty.
- R3: With mode bit 0 set (MSB-justified), frame sync is high for the left word, and the left MSB is on the data line during the first bit clock after the sync rises. Data changes on falling bit clock edges and is sampled on rising ones, left word before right word, MSB first.
- R4: With mode bit 0 clear (I2S), frame sync is low for the left word and every data bit lags the sync edge by one bit clock. The first bit after sync rises is the left LSB, and the right MSB follows it.
- R5: Mode bit 5 routes the transmit serial stream into the receiver, so words written to the data index come back unchanged, in order, in both framings.
- R6: If the transmit queue is empty when a frame starts and playback is on, the frame carries zeros and the sticky underrun flag (status bit 5) is set.
- R7: A captured word that finds the receive queue full is dropped and the sticky overrun flag (status bit 6) is set. Writing 1 to clear-register bit 5 clears underrun and writing 1 to bit 6 clears overrun.
- R8: Control bits 11:8 set the transmit threshold and bits 15:12 set the receive threshold. The transmit request (status bit 3, tx_dreq) is high while the transmit fill is at or below its threshold, and the receive request (status bit 4, rx_dreq) is high while the receive fill is at or above its threshold.
- R9: Mask bits 3, 4, 5 and 6 enable status bits 3, 4, 5 and 6 onto irq, and irq is low when no enabled flag is set.
- R10: Control bit 2 set makes the block drive the bit clock (bclk_oe high), with each half period lasting divider+1 system clocks. When it is clear, the block follows bclk_in and holds bclk_out low.
- R11: Control bit 0 enables the link, and frames run while it is set and at least one of the mode bits 4 (playback off) and 3 (recording off) is clear. With playback off, frames carry zeros, nothing is popped and no underrun is raised. Status bit 2 is busy during a frame, and status bit 7 (link off) is set when the enable bit is clear and no frame is running.
- R12: Writing control bit 3 as 1 and then as 0 returns every register and both queues to their reset values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register word index |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| irq | output | 1 | Interrupt |
| tx_dreq | output | 1 | Transmit service request |
| rx_dreq | output | 1 | Receive service request |
| bclk_in | input | 1 | External bit clock |
| bclk_out | output | 1 | Generated bit clock |
| bclk_oe | output | 1 | Bit clock output enable |
| fsync_out | output | 1 | Frame sync |
| sdata_out | output | 1 | Serial transmit data |
| sdata_in | input | 1 | Serial receive data |

## Verification
The hardest condition to reach from the ports is a receive overrun, because it needs more than sixteen frames captured while nothing is read. The stimulus enables loopback with an empty transmit queue, so the link also produces underrun frames of zeros, and it lets the link run for about twenty frames before stopping it. Exactly sixteen zero words must then drain out. In I2S framing the word lags the frame by one bit, and the loopback scoreboard shows that the lag is carried across the frame boundary.

// File: rtl/sal_pkg.sv
package sal_pkg;
    localparam int SAMPLE_W = 16;
    localparam int WORD_W   = 2 * SAMPLE_W;
    localparam int DIV_W    = 8;
    localparam int TH_W     = 4;

    localparam logic [2:0] RA_CTRL = 3'd0;
    localparam logic [2:0] RA_MODE = 3'd1;
    localparam logic [2:0] RA_STAT = 3'd2;
    localparam logic [2:0] RA_MASK = 3'd3;
    localparam logic [2:0] RA_CLR  = 3'd4;
    localparam logic [2:0] RA_DIV  = 3'd5;
    localparam logic [2:0] RA_DATA = 3'd6;

    typedef enum logic [1:0] {
        FR_IDLE  = 2'd0,
        FR_LEFT  = 2'd1,
        FR_RIGHT = 2'd2
    } frame_state_e;

    typedef struct packed {
        logic [TH_W-1:0] rx_th;
        logic [TH_W-1:0] tx_th;
        logic            soft_rst;
        logic            bclk_drive;
        logic            link_en;
    } ctrl_t;

    typedef struct packed {
        logic loopback;
        logic play_off;
        logic rec_off;
        logic msb_just;
    } mode_t;
endpackage

// File: rtl/sal_fifo.sv
module sal_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clr,
    input  logic                   push,
    input  logic [W-1:0]           wdata,
    input  logic                   pop,
    output logic [W-1:0]           rdata,
    output logic [$clog2(DEPTH):0] count,
    output logic                   full,
    output logic                   empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic [W-1:0]  mem_q [DEPTH];
    logic [AW-1:0] wr_ptr_q, rd_ptr_q;
    logic [CW-1:0] cnt_q;
    logic          do_push, do_pop;

    assign full    = (cnt_q == CW'(DEPTH));
    assign empty   = (cnt_q == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem_q[rd_ptr_q];
    assign count   = cnt_q;

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem_q[wr_ptr_q] <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            cnt_q    <= '0;
        end else if (clr) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            cnt_q    <= '0;
        end else begin
            if (do_push) begin
                wr_ptr_q <= (wr_ptr_q == AW'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
            end
            if (do_pop) begin
                rd_ptr_q <= (rd_ptr_q == AW'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;
            end
            case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    AST_FIFO_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !clr) |=> (full && count == $past(count))); // R2
endmodule

// File: rtl/sal_bclk_gen.sv
module sal_bclk_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             run,
    input  logic             drive,
    input  logic [DIV_W-1:0] div,
    input  logic             bclk_in,
    output logic             bclk_out,
    output logic             rise,
    output logic             fall
);
    logic [DIV_W-1:0] cnt_q;
    logic             bclk_q;
    logic [2:0]       sync_q;
    logic             tick;

    assign tick     = run && drive && (cnt_q == '0);
    assign bclk_out = bclk_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            bclk_q <= 1'b0;
            sync_q <= '0;
        end else if (clr) begin
            cnt_q  <= '0;
            bclk_q <= 1'b0;
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[1:0], bclk_in};
            if (!run || !drive) begin
                cnt_q  <= div;
                bclk_q <= 1'b0;
            end else if (tick) begin
                cnt_q  <= div;
                bclk_q <= ~bclk_q;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    always_comb begin
        if (drive) begin
            rise = tick && !bclk_q;
            fall = tick && bclk_q;
        end else begin
            rise = run && sync_q[1] && !sync_q[2];
            fall = run && !sync_q[1] && sync_q[2];
        end
    end

    AST_BCLK_QUIET_SLAVE: assert property (@(posedge clk) disable iff (!rst_n)
        !drive |=> !bclk_out); // R10
endmodule

// File: rtl/sal_framer.sv
module sal_framer
    import sal_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         go,
    input  logic         msb_just,
    input  logic         play_on,
    input  logic         rec_on,
    input  logic         loopback,
    input  logic         rise,
    input  logic         fall,
    input  logic [W-1:0] tx_word,
    input  logic         tx_empty,
    input  logic         rx_full,
    input  logic         sdi,
    output logic         tx_pop,
    output logic         rx_push,
    output logic [W-1:0] rx_word,
    output logic         underrun_set,
    output logic         overrun_set,
    output logic         fsync,
    output logic         sdo,
    output logic         busy
);
    localparam int SW   = $clog2(W);
    localparam int HALF = W / 2;

    frame_state_e  state_q, state_d;
    logic [SW-1:0] slot_q, slot_d;
    logic [W-1:0]  tx_sh_q, rx_sh_q;
    logic          prev_q, armed_q;
    logic          load, last_slot, half_slot, sdi_sel, word_done;

    assign last_slot = (slot_q == SW'(W - 1));
    assign half_slot = (slot_q == SW'(HALF - 1));

    // next-state logic
    always_comb begin
        state_d = state_q;
        slot_d  = slot_q;
        load    = 1'b0;
        if (fall) begin
            unique case (state_q)
                FR_IDLE: begin
                    if (go) begin
                        state_d = FR_LEFT;
                        slot_d  = '0;
                        load    = 1'b1;
                    end
                end
                FR_LEFT: begin
                    slot_d = slot_q + 1'b1;
                    if (half_slot) state_d = FR_RIGHT;
                end
                FR_RIGHT: begin
                    slot_d = slot_q + 1'b1;
                    if (last_slot) begin
                        slot_d = '0;
                        if (go) begin
                            state_d = FR_LEFT;
                            load    = 1'b1;
                        end else begin
                            state_d = FR_IDLE;
                        end
                    end
                end
                default: state_d = FR_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FR_IDLE;
            slot_q  <= '0;
        end else if (clr) begin
            state_q <= FR_IDLE;
            slot_q  <= '0;
        end else begin
            state_q <= state_d;
            slot_q  <= slot_d;
        end
    end

    // outputs and datapath
    assign busy         = (state_q != FR_IDLE);
    assign tx_pop       = load && play_on && !tx_empty;
    assign underrun_set = load && play_on && tx_empty;
    assign sdo          = busy && (msb_just ? tx_sh_q[W-1] : prev_q);
    assign fsync        = busy && (msb_just ? !slot_q[SW-1] : slot_q[SW-1]);
    assign sdi_sel      = loopback ? sdo : sdi;
    assign rx_word      = {rx_sh_q[W-2:0], sdi_sel};
    assign word_done    = rise && busy &&
                          (msb_just ? last_slot : (slot_q == '0 && armed_q));
    assign rx_push      = word_done && rec_on && !rx_full;
    assign overrun_set  = word_done && rec_on && rx_full;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sh_q <= '0;
            rx_sh_q <= '0;
            prev_q  <= 1'b0;
            armed_q <= 1'b0;
        end else if (clr) begin
            tx_sh_q <= '0;
            rx_sh_q <= '0;
            prev_q  <= 1'b0;
            armed_q <= 1'b0;
        end else begin
            if (fall) begin
                prev_q <= tx_sh_q[W-1];
                if (load) begin
                    tx_sh_q <= tx_pop ? tx_word : '0;
                end else if (state_d == FR_IDLE) begin
                    tx_sh_q <= '0;
                end else begin
                    tx_sh_q <= tx_sh_q << 1;
                end
            end
            if (rise && busy) begin
                rx_sh_q <= rx_word;
                if (last_slot) armed_q <= 1'b1;
            end
            if (!busy) armed_q <= 1'b0;
        end
    end

    AST_I2S_LEFT_SYNC_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FR_LEFT && !msb_just) |-> !fsync); // R4
    AST_MSB_LEFT_SYNC_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FR_LEFT && msb_just) |-> fsync); // R3
    AST_NO_POP_PLAY_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !play_on |-> (!tx_pop && !underrun_set)); // R11
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FR_IDLE) |-> (!sdo && !fsync && !rx_push)); // R11
endmodule

// File: rtl/serial_audio_link.sv
module serial_audio_link
    import sal_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  bus_addr,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq,
    output logic        tx_dreq,
    output logic        rx_dreq,
    input  logic        bclk_in,
    output logic        bclk_out,
    output logic        bclk_oe,
    output logic        fsync_out,
    output logic        sdata_out,
    input  logic        sdata_in
);
    localparam int DEPTH = 16;
    localparam int CW    = $clog2(DEPTH) + 1;

    ctrl_t            ctrl_q;
    mode_t            mode_q;
    logic [3:0]       mask_q;
    logic [DIV_W-1:0] div_q;
    logic             tur_q, ror_q;
    logic [31:0]      rdata_q;
    logic             srst;

    logic             wr_ctrl, wr_mode, wr_mask, wr_clr, wr_div, wr_data, rd_data;
    logic             clr_tur, clr_ror;

    logic [WORD_W-1:0] tx_head, rx_head, rx_word;
    logic [CW-1:0]     tx_cnt, rx_cnt;
    logic              tx_full, tx_empty, rx_full, rx_empty;
    logic              tx_pop, rx_push, under_set, over_set;
    logic              rise, fall, busy, go, run, play_on, rec_on;
    logic              tx_req, rx_req, link_off;
    logic [7:0]        status;

    assign srst    = ctrl_q.soft_rst;
    assign wr_ctrl = bus_wr && bus_addr == RA_CTRL;
    assign wr_mode = bus_wr && bus_addr == RA_MODE;
    assign wr_mask = bus_wr && bus_addr == RA_MASK;
    assign wr_clr  = bus_wr && bus_addr == RA_CLR;
    assign wr_div  = bus_wr && bus_addr == RA_DIV;
    assign wr_data = bus_wr && bus_addr == RA_DATA && !srst;
    assign rd_data = bus_rd && bus_addr == RA_DATA && !srst;
    assign clr_tur = wr_clr && bus_wdata[5];
    assign clr_ror = wr_clr && bus_wdata[6];

    assign play_on = !mode_q.play_off;
    assign rec_on  = !mode_q.rec_off;
    assign go      = ctrl_q.link_en && (play_on || rec_on);
    assign run     = ctrl_q.link_en || busy;

    // control register: a set reset bit wipes the other fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_ctrl) begin
            if (bus_wdata[3]) begin
                ctrl_q          <= '0;
                ctrl_q.soft_rst <= 1'b1;
            end else begin
                ctrl_q.rx_th      <= bus_wdata[15:12];
                ctrl_q.tx_th      <= bus_wdata[11:8];
                ctrl_q.soft_rst   <= 1'b0;
                ctrl_q.bclk_drive <= bus_wdata[2];
                ctrl_q.link_en    <= bus_wdata[0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '{loopback: 1'b0, play_off: 1'b1, rec_off: 1'b1, msb_just: 1'b0};
            mask_q <= '0;
            div_q  <= '0;
            tur_q  <= 1'b0;
            ror_q  <= 1'b0;
        end else if (srst) begin
            mode_q <= '{loopback: 1'b0, play_off: 1'b1, rec_off: 1'b1, msb_just: 1'b0};
            mask_q <= '0;
            div_q  <= '0;
            tur_q  <= 1'b0;
            ror_q  <= 1'b0;
        end else begin
            if (wr_mode) begin
                mode_q.loopback <= bus_wdata[5];
                mode_q.play_off <= bus_wdata[4];
                mode_q.rec_off  <= bus_wdata[3];
                mode_q.msb_just <= bus_wdata[0];
            end
            if (wr_mask) mask_q <= bus_wdata[6:3];
            if (wr_div)  div_q  <= bus_wdata[DIV_W-1:0];
            if (under_set)    tur_q <= 1'b1;
            else if (clr_tur) tur_q <= 1'b0;
            if (over_set)     ror_q <= 1'b1;
            else if (clr_ror) ror_q <= 1'b0;
        end
    end

    assign tx_req   = (tx_cnt <= CW'(ctrl_q.tx_th));
    assign rx_req   = (rx_cnt >= CW'(ctrl_q.rx_th));
    assign link_off = !ctrl_q.link_en && !busy;
    assign status   = {link_off, ror_q, tur_q, rx_req, tx_req, busy, !rx_empty, !tx_full};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (bus_rd) begin
            unique case (bus_addr)
                RA_CTRL: rdata_q <= {16'b0, ctrl_q.rx_th, ctrl_q.tx_th, 4'b0,
                                     ctrl_q.soft_rst, ctrl_q.bclk_drive, 1'b0, ctrl_q.link_en};
                RA_MODE: rdata_q <= {26'b0, mode_q.loopback, mode_q.play_off,
                                     mode_q.rec_off, 2'b0, mode_q.msb_just};
                RA_STAT: rdata_q <= {24'b0, status};
                RA_MASK: rdata_q <= {25'b0, mask_q, 3'b0};
                RA_DIV:  rdata_q <= {{(32-DIV_W){1'b0}}, div_q};
                RA_DATA: rdata_q <= rx_empty ? '0 : rx_head;
                default: rdata_q <= '0;
            endcase
        end
    end

    sal_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_tx_fifo (
        .clk(clk), .rst_n(rst_n), .clr(srst),
        .push(wr_data), .wdata(bus_wdata), .pop(tx_pop), .rdata(tx_head),
        .count(tx_cnt), .full(tx_full), .empty(tx_empty)
    );

    sal_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_rx_fifo (
        .clk(clk), .rst_n(rst_n), .clr(srst),
        .push(rx_push), .wdata(rx_word), .pop(rd_data), .rdata(rx_head),
        .count(rx_cnt), .full(rx_full), .empty(rx_empty)
    );

    sal_bclk_gen #(.DIV_W(DIV_W)) u_bclk (
        .clk(clk), .rst_n(rst_n), .clr(srst), .run(run),
        .drive(ctrl_q.bclk_drive), .div(div_q), .bclk_in(bclk_in),
        .bclk_out(bclk_out), .rise(rise), .fall(fall)
    );

    sal_framer #(.W(WORD_W)) u_framer (
        .clk(clk), .rst_n(rst_n), .clr(srst), .go(go),
        .msb_just(mode_q.msb_just), .play_on(play_on), .rec_on(rec_on),
        .loopback(mode_q.loopback), .rise(rise), .fall(fall),
        .tx_word(tx_head), .tx_empty(tx_empty), .rx_full(rx_full), .sdi(sdata_in),
        .tx_pop(tx_pop), .rx_push(rx_push), .rx_word(rx_word),
        .underrun_set(under_set), .overrun_set(over_set),
        .fsync(fsync_out), .sdo(sdata_out), .busy(busy)
    );

    assign bus_rdata = rdata_q;
    assign bclk_oe   = ctrl_q.bclk_drive;
    assign tx_dreq   = tx_req;
    assign rx_dreq   = rx_req;
    assign irq       = |(mask_q & status[6:3]);

    AST_TUR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (tur_q && !clr_tur && !srst) |=> tur_q); // R6
    AST_ROR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ror_q && !clr_ror && !srst) |=> ror_q); // R7
    AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> !irq); // R9
    AST_SOFT_RESET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> (!busy && rx_empty)); // R12
endmodule

// File: tb/serial_audio_link_test.sv
`timescale 1ns/1ps
module serial_audio_link_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, tx_dreq, rx_dreq, bclk_out, bclk_oe, fsync_out, sdata_out;
    logic        bclk_in = 1'b0, sdata_in = 1'b0, ext_en = 1'b0;

    int total = 0, failed = 0;
    logic [31:0] exp_q[$];

    localparam logic [2:0] A_CTRL = 0, A_MODE = 1, A_STAT = 2, A_MASK = 3,
                           A_CLR = 4, A_DIV = 5, A_DATA = 6;

    serial_audio_link uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .tx_dreq(tx_dreq),
        .rx_dreq(rx_dreq), .bclk_in(bclk_in), .bclk_out(bclk_out), .bclk_oe(bclk_oe),
        .fsync_out(fsync_out), .sdata_out(sdata_out), .sdata_in(sdata_in)
    );

    always #2 clk = ~clk;

    initial begin
        forever begin
            repeat (5) @(negedge clk);
            if (ext_en) bclk_in = ~bclk_in;
        end
    end

    task automatic summary();
        $display("%0d/%0d checks passed", total - failed, total);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; failed++;
        $display("FAIL watchdog: actual=hung expected=done");
        summary();
        $finish;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            failed++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    // driver: push to design and to scoreboard
    task automatic send(input logic [31:0] w);
        wr(A_DATA, w);
        exp_q.push_back(w);
    endtask

    // monitor: pop captured words and compare against scoreboard
    task automatic collect(input string tag);
        logic [31:0] d;
        while (exp_q.size() > 0) begin
            rd(A_DATA, d);
            chk(tag, d, exp_q.pop_front());
        end
    endtask

    task automatic drain_zero(input string tag, output int n);
        logic [31:0] s, d;
        n = 0;
        for (int i = 0; i < 20; i++) begin
            rd(A_STAT, s);
            if (!s[1]) break;
            rd(A_DATA, d);
            chk(tag, d, 32'h0);
            n++;
        end
    endtask

    task automatic wait_off(input string tag);
        logic [31:0] s;
        bit seen = 0;
        for (int i = 0; i < 3000; i++) begin
            rd(A_STAT, s);
            if (s[7]) begin seen = 1; break; end
        end
        chk(tag, {31'b0, seen}, 32'h1);
    endtask

    initial begin
        logic [31:0] d;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // reset state
        rd(A_STAT, d); chk("R1 status", d, 32'h99);
        rd(A_MODE, d); chk("R1 mode", d, 32'h18);
        rd(A_CTRL, d); chk("R1 ctrl", d, 32'h0);
        chk("R9 irq idle", {31'b0, irq}, 32'h0);
        chk("R10 oe idle", {31'b0, bclk_oe}, 32'h0);

        // thresholds with link off
        wr(A_CTRL, 32'h1200);
        send(32'hA5C3_1234);
        send(32'h0F0F_7E81);
        rd(A_STAT, d); chk("R8 treq at th", {31'b0, d[3]}, 32'h1);
        send(32'h5555_AAAA);
        rd(A_STAT, d); chk("R8 treq above th", {31'b0, d[3]}, 32'h0);
        chk("R8 tx_dreq", {31'b0, tx_dreq}, 32'h0);

        // MSB-justified loopback, master clock
        wr(A_DIV, 32'h1);
        wr(A_MODE, 32'h21);
        wr(A_MASK, 32'h20);
        wr(A_CTRL, 32'h1205);
        chk("R10 oe master", {31'b0, bclk_oe}, 32'h1);
        @(posedge fsync_out); @(posedge bclk_out); #1;
        chk("R3 msb at sync", {31'b0, sdata_out}, 32'h1);
        rd(A_STAT, d); chk("R11 busy", {30'b0, d[7], d[2]}, 32'h1);
        repeat (700) @(negedge clk);
        wr(A_CTRL, 32'h1204);
        wait_off("R11 stop");
        rd(A_STAT, d); chk("R6 underrun", {31'b0, d[5]}, 32'h1);
        chk("R9 irq tur", {31'b0, irq}, 32'h1);
        collect("R3 R5 msb loopback");
        drain_zero("R6 zero fill", n);
        wr(A_CLR, 32'h20);
        rd(A_STAT, d); chk("R7 clear tur", {31'b0, d[5]}, 32'h0);
        chk("R9 irq cleared", {31'b0, irq}, 32'h0);

        // I2S loopback
        wr(A_MODE, 32'h20);
        send(32'h0001_4000);
        send(32'h1357_9BDF);
        send(32'hFFFF_0000);
        wr(A_CTRL, 32'h1205);
        @(posedge fsync_out); @(posedge bclk_out); #1;
        chk("R4 left lsb after sync", {31'b0, sdata_out}, 32'h1);
        @(posedge bclk_out); #1;
        chk("R4 right msb", {31'b0, sdata_out}, 32'h0);
        @(posedge bclk_out); #1;
        chk("R4 right bit14", {31'b0, sdata_out}, 32'h1);
        repeat (700) @(negedge clk);
        wr(A_CTRL, 32'h1204);
        wait_off("R11 stop i2s");
        collect("R4 R5 i2s loopback");
        drain_zero("R6 zero fill i2s", n);
        wr(A_CLR, 32'h20);

        // playback disabled: zeros, nothing popped, no underrun
        wr(A_DATA, 32'hDEAD_BEEF);
        wr(A_DATA, 32'hCAFE_F00D);
        wr(A_DATA, 32'h1234_5678);
        wr(A_MODE, 32'h30);
        wr(A_CTRL, 32'h1205);
        repeat (400) @(negedge clk);
        wr(A_CTRL, 32'h1204);
        wait_off("R11 stop play off");
        rd(A_STAT, d);
        chk("R11 no underrun", {31'b0, d[5]}, 32'h0);
        chk("R11 tx not popped", {31'b0, d[3]}, 32'h0);
        drain_zero("R11 zeros sent", n);
        chk("R11 words captured", {31'b0, n > 0}, 32'h1);

        // soft reset
        wr(A_MASK, 32'h78);
        wr(A_CTRL, 32'h8);
        wr(A_CTRL, 32'h0);
        rd(A_STAT, d); chk("R12 status", d, 32'h99);
        rd(A_MODE, d); chk("R12 mode", d, 32'h18);
        rd(A_MASK, d); chk("R12 mask", d, 32'h0);
        rd(A_DIV, d);  chk("R12 div", d, 32'h0);

        // overrun
        wr(A_DIV, 32'h1);
        wr(A_MODE, 32'h20);
        wr(A_MASK, 32'h40);
        wr(A_CTRL, 32'h1205);
        repeat (2700) @(negedge clk);
        chk("R8 rx_dreq", {31'b0, rx_dreq}, 32'h1);
        wr(A_CTRL, 32'h1204);
        wait_off("R11 stop overrun");
        rd(A_STAT, d); chk("R7 overrun", {31'b0, d[6]}, 32'h1);
        chk("R2 rx full tx not full", {30'b0, d[1], d[0]}, 32'h3);
        chk("R9 irq ror", {31'b0, irq}, 32'h1);
        drain_zero("R7 drain", n);
        chk("R2 depth 16", n, 32'd16);
        wr(A_CLR, 32'h40);
        rd(A_STAT, d); chk("R7 clear ror", {31'b0, d[6]}, 32'h0);
        chk("R9 irq off", {31'b0, irq}, 32'h0);
        wr(A_CLR, 32'h60);

        // transmit queue full
        for (int i = 0; i < 17; i++) wr(A_DATA, 32'h0);
        rd(A_STAT, d); chk("R2 tx full", {31'b0, d[0]}, 32'h0);
        wr(A_CTRL, 32'h8);
        wr(A_CTRL, 32'h0);

        // external bit clock
        wr(A_MODE, 32'h21);
        wr(A_CTRL, 32'h1201);
        chk("R10 oe slave", {31'b0, bclk_oe}, 32'h0);
        ext_en = 1'b1;
        send(32'h6B2D_E817);
        repeat (1100) @(negedge clk);
        chk("R10 bclk_out low", {31'b0, bclk_out}, 32'h0);
        wr(A_CTRL, 32'h1200);
        wait_off("R11 stop slave");
        collect("R10 slave loopback");
        ext_en = 1'b0;

        summary();
        $finish;
    end
endmodule